// File: doc/BRIEF.md
# Byte Write Qualifier for a Synchronous Memory Word

This block sits in front of a 32-bit synchronous memory array. On every rising clock edge it looks at the write control inputs and decides which of the four data bytes will be written into the addressed word. The result is registered as a four-bit write mask, and the incoming write data is registered on the same edge. The array then writes with the mask, the data and the registered address all from the same cycle.

A global write input, when low, writes the whole word. If it is high, individual byte selects act only while a separate byte-write gate is low. A low processor address strobe on the same edge blocks the byte-select path. A registered write-active flag is raised whenever at least one byte is being written. The output stage uses this flag to switch its data drivers to high impedance. A cycle in which the gate is open but no byte select is low counts as a read.

Top module: `byte_write_ctl`

## Requirements
- R1: While reset is asserted, and after it is released until the first qualifying edge, the write mask, the write-active flag and the registered data are all zero.
- R2: A low global write on a clock edge sets all four mask bits on that edge, whatever the gate, byte selects and processor strobe are.
- R3: With global write high and the byte-write gate high, the mask is all zero after the edge, whatever the byte selects are.
- R4: With global write high, gate low and processor strobe high, mask bit i is set after the edge exactly when byte select i is low. Bit 0 covers data bits 7:0, bit 1 covers 15:8, bit 2 covers 23:16 and bit 3 covers 31:24, and any mix of bits may be set together.
- R5: With global write high and the processor strobe low, the mask is all zero after the edge, even when the gate and selects are low.
- R6: With global write high, gate low, strobe high and all byte selects high, the write-active flag is low after the edge.
- R7: The registered write data after an edge equals the write data present on that edge, so data and mask move together.
- R8: The write-active flag, which also turns the data drivers off, is high exactly when at least one mask bit is set.
- R9: Mask and flag change only on the clock edge. New inputs applied between edges have no effect on them until the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| glb_wr_n | input | 1 | Global write, active low, writes all bytes |
| byte_gate_n | input | 1 | Byte-write gate, active low, lets byte selects through |
| byte_sel_n | input | 4 | Per-byte selects, active low, bit i for byte i |
| proc_strobe_n | input | 1 | Processor address strobe, active low, vetoes byte writes |
| wr_data | input | 32 | Write data sampled on the edge |
| wr_mask | output | 4 | Registered byte write mask, active high |
| wr_active | output | 1 | Registered write flag, also forces data drivers off |
| wr_data_q | output | 32 | Write data registered with the mask |

## Verification
The hardest case to produce from the ports is the overlap of controls: the processor strobe low while the gate and several selects are also low, and the global write low while the strobe veto is active. In the first case the veto has to win. In the second the global write has to win. Directed cycles set up each overlap on purpose and also cover the empty-gate case. A long run of random control and data values then follows, and a behavioural reference model checks each of those cycles. Right after each new set of inputs is applied, the bench also checks that the outputs have not moved yet.

// File: rtl/byte_write_ctl.sv
module byte_write_ctl #(
  parameter int NUM_BYTES = 4,
  parameter int BYTE_W    = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        glb_wr_n,
  input  logic                        byte_gate_n,
  input  logic [NUM_BYTES-1:0]        byte_sel_n,
  input  logic                        proc_strobe_n,
  input  logic [NUM_BYTES*BYTE_W-1:0] wr_data,
  output logic [NUM_BYTES-1:0]        wr_mask,
  output logic                        wr_active,
  output logic [NUM_BYTES*BYTE_W-1:0] wr_data_q
);
  localparam int DW = NUM_BYTES * BYTE_W;

  logic               byte_path_open;
  logic [NUM_BYTES-1:0] mask_d;

  assign byte_path_open = ~byte_gate_n & proc_strobe_n;

  for (genvar i = 0; i < NUM_BYTES; i++) begin : g_lane
    assign mask_d[i] = ~glb_wr_n | (byte_path_open & ~byte_sel_n[i]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_mask   <= '0;
      wr_active <= 1'b0;
      wr_data_q <= '0;
    end else begin
      wr_mask   <= mask_d;
      wr_active <= |mask_d;
      wr_data_q <= wr_data;
    end
  end

  assert_global_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !glb_wr_n |=> (wr_mask == {NUM_BYTES{1'b1}}));

  assert_gate_closed_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (glb_wr_n && byte_gate_n) |=> (wr_mask == '0));

  assert_byte_pass_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (glb_wr_n && !byte_gate_n && proc_strobe_n) |=> (wr_mask == ~$past(byte_sel_n)));

  assert_strobe_veto_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (glb_wr_n && !proc_strobe_n) |=> (wr_mask == '0));

  assert_empty_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (glb_wr_n && !byte_gate_n && proc_strobe_n && (&byte_sel_n)) |=> !wr_active);

  assert_data_with_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (wr_data_q == $past(wr_data)));

  assert_flag_matches_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_active == (wr_mask != '0));

  initial begin
    if (DW != NUM_BYTES * BYTE_W) $error("width mismatch");
  end
endmodule

// File: tb/byte_write_ctl_test.sv
module byte_write_ctl_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        glb_wr_n, byte_gate_n, proc_strobe_n;
  logic [3:0]  byte_sel_n;
  logic [31:0] wr_data;
  logic [3:0]  wr_mask;
  logic        wr_active;
  logic [31:0] wr_data_q;

  int checks = 0;
  int failures = 0;
  logic [3:0]  exp_mask;
  logic        exp_act;
  logic [31:0] exp_data;
  string       exp_tag;

  byte_write_ctl uut (
    .clk(clk), .rst_n(rst_n), .glb_wr_n(glb_wr_n), .byte_gate_n(byte_gate_n),
    .byte_sel_n(byte_sel_n), .proc_strobe_n(proc_strobe_n), .wr_data(wr_data),
    .wr_mask(wr_mask), .wr_active(wr_active), .wr_data_q(wr_data_q)
  );

  always #5 clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic predict();
    int n;
    exp_data = wr_data;
    if (!glb_wr_n) begin
      exp_mask = 4'hF; exp_tag = "R2";
    end else if (byte_gate_n) begin
      exp_mask = 4'h0; exp_tag = "R3";
    end else if (!proc_strobe_n) begin
      exp_mask = 4'h0; exp_tag = "R5";
    end else begin
      for (int b = 0; b < 4; b++) exp_mask[b] = (byte_sel_n[b] == 1'b0);
      exp_tag = (byte_sel_n == 4'hF) ? "R6" : "R4";
    end
    n = 0;
    for (int b = 0; b < 4; b++) if (exp_mask[b]) n++;
    exp_act = (n > 0);
  endtask

  task automatic step(input logic g, input logic gate, input logic [3:0] sel,
                      input logic strb, input logic [31:0] d);
    logic [3:0] held_mask;
    logic       held_act;
    held_mask = wr_mask;
    held_act  = wr_active;
    glb_wr_n = g; byte_gate_n = gate; byte_sel_n = sel; proc_strobe_n = strb; wr_data = d;
    predict();
    #1;
    check(wr_mask == held_mask && wr_active == held_act, "R9",
          {27'd0, wr_active, wr_mask}, {27'd0, held_act, held_mask});
    @(negedge clk);
    check(wr_mask == exp_mask, exp_tag, {28'd0, wr_mask}, {28'd0, exp_mask});
    check(wr_active == exp_act, (exp_tag == "R6") ? "R6" : "R8",
          {31'd0, wr_active}, {31'd0, exp_act});
    check(wr_data_q == exp_data, "R7", wr_data_q, exp_data);
  endtask

  initial begin
    #200000;
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    glb_wr_n = 1'b0; byte_gate_n = 1'b0; byte_sel_n = 4'h0; proc_strobe_n = 1'b1;
    wr_data = 32'hDEAD_BEEF;
    repeat (3) @(negedge clk);
    check(wr_mask == 4'h0 && !wr_active && wr_data_q == 32'h0, "R1",
          {27'd0, wr_active, wr_mask}, 32'h0);
    rst_n = 1'b1;
    glb_wr_n = 1'b1; byte_gate_n = 1'b1; byte_sel_n = 4'hF;
    @(negedge clk);
    check(wr_mask == 4'h0 && !wr_active, "R1", {27'd0, wr_active, wr_mask}, 32'h0);

    step(1'b0, 1'b1, 4'hF, 1'b1, 32'h1111_2222); // R2 global alone
    step(1'b0, 1'b0, 4'hA, 1'b0, 32'h3333_4444); // R2 global beats veto
    step(1'b1, 1'b1, 4'h0, 1'b1, 32'h5555_6666); // R3 gate closed
    step(1'b1, 1'b0, 4'hE, 1'b1, 32'h0000_00AA); // R4 byte 0 only
    step(1'b1, 1'b0, 4'h7, 1'b1, 32'hBB00_0000); // R4 byte 3 only
    step(1'b1, 1'b0, 4'h5, 1'b1, 32'h1234_5678); // R4 bytes 1 and 3
    step(1'b1, 1'b0, 4'h0, 1'b0, 32'h9ABC_DEF0); // R5 veto all selects
    step(1'b1, 1'b0, 4'hF, 1'b1, 32'h0F0F_0F0F); // R6 empty gate
    step(1'b1, 1'b0, 4'h0, 1'b1, 32'hFFFF_FFFF); // R4 all bytes

    for (int k = 0; k < 400; k++) begin
      logic [7:0] r;
      r = 8'($urandom);
      step(r[0] | r[1], r[2], r[6:3], r[7] | r[5], $urandom);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule